// File: doc/BRIEF.md
# Pipelined Add/Subtract Unit

A clocked arithmetic unit that accepts two 16-bit operands and a 2-bit operation code on every rising clock edge and returns a 16-bit result with carry, signed-overflow and ready flags after a fixed latency. The adder is a plain ripple-carry chain. It is cut into equal slices, with one slice per pipeline stage. Each stage registers its part of the sum, its carry out, and the operand bits that later slices still need. This lets a new operation enter on every clock while earlier ones are still in flight.

Subtraction returns the second operand minus the first. The no-operation code and the reserved code both give a zero result with both flags cleared. The ready flag moves down the pipeline together with the data. It is low after reset until the first accepted operation reaches the outputs, and from then on it is high on every cycle. The reset is asynchronous and active-low.

Top module: `rca_pipe`

## Requirements
- R1: With op_i = 2'b01, the outputs show result_o = opnd_b_i + opnd_a_i modulo 2^16, and carry_o is bit 16 of the unsigned sum.
- R2: With op_i = 2'b10, the outputs show result_o = opnd_b_i - opnd_a_i modulo 2^16, and carry_o is 1 exactly when opnd_b_i >= opnd_a_i as unsigned values (no borrow).
- R3: ovf_o flags two's-complement overflow. For an add it is 1 when both operands have the same sign bit and the result's sign bit differs from it. For a subtract it is 1 when the operand sign bits differ and the result's sign bit differs from that of opnd_b_i.
- R4: With op_i = 2'b00 (no-op), result_o is 0, carry_o is 0 and ovf_o is 0, whatever the operands are.
- R5: With op_i = 2'b11 (reserved), the outputs behave exactly as for 2'b00.
- R6: The operation sampled at rising edge N appears on the outputs just after edge N+3 and holds until edge N+4. One result is produced per cycle, in input order, with no gaps.
- R7: After reset is released, ready_o stays 0 through the first three rising edges. From the fourth edge onward it is 1 on every cycle.
- R8: While rst_ni is low, all outputs are 0 at once, without waiting for a clock edge, and nothing sampled before the reset appears afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Operation: 00 no-op, 01 add, 10 subtract, 11 reserved |
| opnd_a_i | input | 16 | First operand (subtrahend for subtract) |
| opnd_b_i | input | 16 | Second operand (minuend for subtract) |
| result_o | output | 16 | Result of the operation sampled three edges earlier |
| carry_o | output | 1 | Carry out of bit 15; for a subtract, 1 means no borrow |
| ovf_o | output | 1 | Signed overflow |
| ready_o | output | 1 | Outputs hold a real result |

## Verification
The assertions assume that an operation is present on every clock after reset is released. They also assume that the inputs seen at a rising edge are the inputs of the operation the outputs show four edges later. For this reason the checker refers back to inputs only after it has counted four edges since reset. The stimulus never leaves a gap in the input stream. It releases reset on a falling edge and drives the first operation in that same step, and it only changes inputs on falling edges. The directed operands cover the carry, borrow and overflow boundaries, and the random operands cover all four codes.

// File: rtl/rca_pkg.sv
package rca_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'b00,
    OP_ADD = 2'b01,
    OP_SUB = 2'b10,
    OP_RSV = 2'b11
  } rca_op_e;
endpackage

// File: rtl/rca_opdecode.sv
module rca_opdecode import rca_pkg::*; #(
  parameter int W = 16
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] opnd_a_i,
  input  logic [W-1:0] opnd_b_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic         cin_o
);
  // zeroed operands make no-op codes fall out of the adder as 0 with clear flags
  always_comb begin
    x_o   = '0;
    y_o   = '0;
    cin_o = 1'b0;
    unique case (rca_op_e'(op_i))
      OP_ADD: begin
        x_o = opnd_b_i;
        y_o = opnd_a_i;
      end
      OP_SUB: begin
        x_o   = opnd_b_i;
        y_o   = ~opnd_a_i;
        cin_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rca_slice_add.sv
module rca_slice_add #(
  parameter int SW = 4
) (
  input  logic [SW-1:0] x_i,
  input  logic [SW-1:0] y_i,
  input  logic          cin_i,
  output logic [SW-1:0] sum_o,
  output logic          cout_o
);
  logic [SW:0] c;

  always_comb begin
    c[0] = cin_i;
    for (int j = 0; j < SW; j++) begin
      sum_o[j] = x_i[j] ^ y_i[j] ^ c[j];
      c[j+1]   = (x_i[j] & y_i[j]) | (c[j] & (x_i[j] ^ y_i[j]));
    end
    cout_o = c[SW];
  end
endmodule

// File: rtl/rca_pipe.sv
module rca_pipe #(
  parameter int W      = 16,
  parameter int SLICES = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] opnd_a_i,
  input  logic [W-1:0] opnd_b_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         ready_o
);
  localparam int SW = W / SLICES;

  logic [W-1:0] dec_x, dec_y;
  logic         dec_cin;

  rca_opdecode #(.W(W)) u_dec (
    .op_i     (op_i),
    .opnd_a_i (opnd_a_i),
    .opnd_b_i (opnd_b_i),
    .x_o      (dec_x),
    .y_o      (dec_y),
    .cin_o    (dec_cin)
  );

  for (genvar s = 0; s < SLICES; s++) begin : g_stg
    localparam int LO = s * SW;
    localparam int HI = (s + 1) * SW;

    logic [W-LO-1:0] in_x, in_y;
    logic            in_c, in_v;
    logic [SW-1:0]   ss;
    logic            sc;
    logic [HI-1:0]   sum_q;
    logic            c_q, v_q;

    if (s == 0) begin : g_src
      assign in_x = dec_x;
      assign in_y = dec_y;
      assign in_c = dec_cin;
      assign in_v = 1'b1;
    end else begin : g_chain
      assign in_x = g_stg[s-1].g_fwd.x_q;
      assign in_y = g_stg[s-1].g_fwd.y_q;
      assign in_c = g_stg[s-1].c_q;
      assign in_v = g_stg[s-1].v_q;
    end

    rca_slice_add #(.SW(SW)) u_add (
      .x_i    (in_x[SW-1:0]),
      .y_i    (in_y[SW-1:0]),
      .cin_i  (in_c),
      .sum_o  (ss),
      .cout_o (sc)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        c_q <= 1'b0;
        v_q <= 1'b0;
      end else begin
        c_q <= sc;
        v_q <= in_v;
      end
    end

    if (s == 0) begin : g_sum0
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sum_q <= '0;
        else         sum_q <= ss;
      end
    end else begin : g_sumn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sum_q <= '0;
        else         sum_q <= {ss, g_stg[s-1].sum_q};
      end
    end

    // operand bits for later slices travel with the partial sum
    if (s < SLICES - 1) begin : g_fwd
      logic [W-HI-1:0] x_q, y_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          x_q <= '0;
          y_q <= '0;
        end else begin
          x_q <= in_x[W-LO-1:SW];
          y_q <= in_y[W-LO-1:SW];
        end
      end
    end else begin : g_last
      logic ovf_q;
      // carry into the sign bit recovered from its sum bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ovf_q <= 1'b0;
        else         ovf_q <= sc ^ (in_x[SW-1] ^ in_y[SW-1] ^ ss[SW-1]);
      end
    end
  end

  assign result_o = g_stg[SLICES-1].sum_q;
  assign carry_o  = g_stg[SLICES-1].c_q;
  assign ovf_o    = g_stg[SLICES-1].g_last.ovf_q;
  assign ready_o  = g_stg[SLICES-1].v_q;
endmodule

// File: rtl/rca_pipe_chk.sv
module rca_pipe_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   op_i,
  input logic [W-1:0] opnd_a_i,
  input logic [W-1:0] opnd_b_i,
  input logic [W-1:0] result_o,
  input logic         carry_o,
  input logic         ovf_o,
  input logic         ready_o
);
  logic [2:0] edges;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          edges <= '0;
    else if (edges != 3'd4) edges <= edges + 3'd1;
  end

  logic hist;
  assign hist = (edges == 3'd4);

  AST_READY_RAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o == hist); // R7

  AST_ADD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist && $past(op_i, 4) == 2'b01) |->
      {carry_o, result_o} == ({1'b0, $past(opnd_b_i, 4)} + {1'b0, $past(opnd_a_i, 4)})); // R1

  AST_SUB_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist && $past(op_i, 4) == 2'b10) |->
      (result_o == $past(opnd_b_i, 4) - $past(opnd_a_i, 4)) &&
      (carry_o == ($past(opnd_b_i, 4) >= $past(opnd_a_i, 4)))); // R2

  AST_ADD_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist && $past(op_i, 4) == 2'b01) |->
      ovf_o == (($past(opnd_a_i[W-1], 4) == $past(opnd_b_i[W-1], 4)) &&
                (result_o[W-1] != $past(opnd_a_i[W-1], 4)))); // R3

  AST_SUB_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist && $past(op_i, 4) == 2'b10) |->
      ovf_o == (($past(opnd_a_i[W-1], 4) != $past(opnd_b_i[W-1], 4)) &&
                (result_o[W-1] != $past(opnd_b_i[W-1], 4)))); // R3

  AST_NOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist && $past(op_i, 4) == 2'b00) |-> (result_o == '0 && !carry_o && !ovf_o)); // R4

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist && $past(op_i, 4) == 2'b11) |-> (result_o == '0 && !carry_o && !ovf_o)); // R5

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (result_o == '0 && !carry_o && !ovf_o && !ready_o)); // R8
endmodule

bind rca_pipe rca_pipe_chk #(.W(W)) u_chk (.*);

// File: tb/rca_pipe_test.sv
module rca_pipe_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  op_i = '0;
  logic [15:0] opnd_a_i = '0;
  logic [15:0] opnd_b_i = '0;
  logic [15:0] result_o;
  logic        carry_o, ovf_o, ready_o;

  rca_pipe uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op_i),
    .opnd_a_i (opnd_a_i),
    .opnd_b_i (opnd_b_i),
    .result_o (result_o),
    .carry_o  (carry_o),
    .ovf_o    (ovf_o),
    .ready_o  (ready_o)
  );

  always #5 clk_i = ~clk_i;

  typedef struct {
    logic [1:0]  op;
    logic [15:0] a;
    logic [15:0] b;
  } stim_t;

  typedef struct {
    logic [1:0]  op;
    logic [15:0] r;
    logic        c;
    logic        v;
  } exp_t;

  stim_t stim_q[$];
  exp_t  exp_q[$];
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  function automatic exp_t model(stim_t s);
    exp_t e;
    logic [16:0] t;
    e.op = s.op;
    e.r = '0; e.c = 1'b0; e.v = 1'b0;
    if (s.op == 2'b01) begin
      t = {1'b0, s.b} + {1'b0, s.a};
      e.r = t[15:0];
      e.c = t[16];
      e.v = (s.a[15] == s.b[15]) && (e.r[15] != s.a[15]);
    end else if (s.op == 2'b10) begin
      e.r = s.b - s.a;
      e.c = (s.b >= s.a);
      e.v = (s.a[15] != s.b[15]) && (e.r[15] != s.b[15]);
    end
    return e;
  endfunction

  function automatic string req_of(logic [1:0] op);
    case (op)
      2'b01:   return "R1 R3 R6";
      2'b10:   return "R2 R3 R6";
      2'b00:   return "R4 R6";
      default: return "R5 R6";
    endcase
  endfunction

  task automatic send(stim_t s);
    op_i = s.op;
    opnd_a_i = s.a;
    opnd_b_i = s.b;
    exp_q.push_back(model(s));
    @(negedge clk_i);
  endtask

  task automatic add_stim(logic [1:0] op, logic [15:0] a, logic [15:0] b);
    stim_t s;
    s.op = op; s.a = a; s.b = b;
    stim_q.push_back(s);
  endtask

  task automatic monitor(int n);
    exp_t e;
    for (int k = 1; k <= n + 3; k++) begin
      @(posedge clk_i);
      #2;
      checks++;
      if (k < 4) begin
        if (ready_o !== 1'b0 || result_o !== 16'h0) begin
          failures++;
          $display("FAIL R7 edge %0d: ready=%b result=%h expected ready=0 result=0000",
                   k, ready_o, result_o);
        end
      end else begin
        e = exp_q.pop_front();
        if (ready_o !== 1'b1 || result_o !== e.r || carry_o !== e.c || ovf_o !== e.v) begin
          failures++;
          $display("FAIL %s R7 edge %0d op=%b: got r=%h c=%b v=%b rdy=%b expected r=%h c=%b v=%b rdy=1",
                   req_of(e.op), k, e.op, result_o, carry_o, ovf_o, ready_o, e.r, e.c, e.v);
        end
      end
    end
  endtask

  // releases reset on a falling edge and feeds the stimulus queue without gaps
  task automatic run_phase();
    int n;
    stim_t f;
    n = stim_q.size();
    f.op = 2'b00; f.a = 16'h0; f.b = 16'h0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    fork
      begin
        foreach (stim_q[i]) send(stim_q[i]);
        for (int i = 0; i < 3; i++) send(f);
      end
      monitor(n);
    join
    stim_q.delete();
    exp_q.delete();
  endtask

  task automatic check_reset(string tag);
    checks++;
    if (result_o !== 16'h0 || carry_o !== 1'b0 || ovf_o !== 1'b0 || ready_o !== 1'b0) begin
      failures++;
      $display("FAIL R8 %s: r=%h c=%b v=%b rdy=%b expected all zero",
               tag, result_o, carry_o, ovf_o, ready_o);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check_reset("initial");

    // phase 1: directed corners then random
    add_stim(2'b01, 16'h0001, 16'h0002);
    add_stim(2'b10, 16'd9,    16'd30);
    add_stim(2'b00, 16'h1234, 16'h5678);
    add_stim(2'b01, 16'h0A80, 16'h0441);
    add_stim(2'b11, 16'hFFFF, 16'hFFFF);
    add_stim(2'b01, 16'h0001, 16'h7FFF);
    add_stim(2'b01, 16'h8000, 16'h8000);
    add_stim(2'b01, 16'hFFFF, 16'h0001);
    add_stim(2'b10, 16'h0001, 16'h8000);
    add_stim(2'b10, 16'h0001, 16'h0000);
    add_stim(2'b10, 16'hBEEF, 16'hBEEF);
    add_stim(2'b10, 16'hFFFF, 16'h7FFF);
    add_stim(2'b00, 16'hFFFF, 16'hFFFF);
    add_stim(2'b11, 16'h8000, 16'h7FFF);
    for (int i = 0; i < 80; i++)
      add_stim(2'($urandom_range(0, 3)), 16'($urandom), 16'($urandom));
    run_phase();

    // mid-stream reset: outputs must clear without a clock edge
    op_i = 2'b01; opnd_a_i = 16'h7FFF; opnd_b_i = 16'h7FFF;
    @(posedge clk_i);
    #1;
    rst_ni = 1'b0;
    #1;
    check_reset("async");
    repeat (2) @(negedge clk_i);
    check_reset("held");

    // phase 2: restart, no stale results, random stream
    for (int i = 0; i < 60; i++)
      add_stim(2'($urandom_range(0, 3)), 16'($urandom), 16'($urandom));
    run_phase();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule